// File: doc/BRIEF.md
# Programmable Conversion Rate Scheduler

This block decides when a two-channel measurement converter begins a conversion. A byte-wide rate register picks one of ten rate codes. In autonomous mode the block issues a one-cycle start strobe once per selected period. It holds a busy flag from each start until the converter reports completion on a done input. It raises a data-valid flag once a complete result exists.

Control software can pause autonomous operation in two ways, a stop control or a standby pin, and the two behave the same. While paused, the block can run a single conversion on request. A supply undervoltage-lockout input blocks every start while it is asserted. The block also drives a resolution select toward the converter. The extended setting is honoured only at the slower rates.

Periods are counted in ticks of an external prescaled timebase whose frequency is the parameter `TICK_HZ`. `TICK_HZ` is assumed to be a multiple of 16. A changed rate takes effect at the next conversion start, so a period that is already running is never cut short.

Top module: `conv_sched`

## Requirements
- R1: With `tick` high in every cycle and completion arriving promptly, the time between autonomous starts for rate code k (0 to 8) is `TICK_HZ*16 >> k` ticks. Code 9 gives the same period as code 8. With `TICK_HZ`=32 this is 512 ticks for code 0 and 2 ticks for codes 8 and 9.
- R2: Only bits [3:0] of a rate write are decoded. Low-nibble values 10 to 15 are reserved: such a write leaves the rate unchanged. `rate_code` reads back `{4'h0, active nibble}`, and its reset value is 8'h08.
- R3: A rate write does not disturb the period already in progress. The new period is applied from the next start onward.
- R4: At each start, `res_ext` is latched as `ext_res_req` AND (code is 6 or lower). At faster codes `res_ext` is 0. The latched value is held until the next start.
- R5: `conv_start` is a one-cycle pulse that rises together with `busy`. `busy` stays high until `conv_done`, and no start occurs while `busy` is high. When the period is shorter than the conversion, the next start comes in the cycle after completion is sampled, which makes the interval max(period, L+1) cycles for a done sampled L cycles after the start.
- R6: While `run_stop` or `standby` is 1, no autonomous start happens, and a conversion already in progress completes. When both return to 0, a start is issued at the next clock edge.
- R7: A `one_shot` pulse while paused and idle yields exactly one conversion, after which the block stays idle. A `one_shot` that arrives while `busy` is high is ignored.
- R8: No start is issued in the cycle after one in which `uvlo` is 1. A start that was held back by `uvlo` is issued at the first edge after `uvlo` returns to 0.
- R9: `data_valid` is 0 after reset. It is cleared by any start issued from the idle state (power-up, leaving a pause, or a one-shot). It is set at completion of a conversion.
- R10: After reset, with `uvlo` low and no pause, the first conversion starts at the first clock edge, in legacy resolution at the 8'h08 rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled timebase tick, one cycle per tick |
| rate_we | input | 1 | Rate register write strobe |
| rate_wdata | input | 8 | Rate register write data |
| run_stop | input | 1 | 1 pauses autonomous conversion |
| standby | input | 1 | Standby pin, 1 pauses autonomous conversion |
| one_shot | input | 1 | Single conversion request |
| ext_res_req | input | 1 | Requests extended resolution |
| uvlo | input | 1 | Supply undervoltage lockout, 1 blocks starts |
| conv_done | input | 1 | Converter completion pulse |
| conv_start | output | 1 | Conversion start strobe |
| res_ext | output | 1 | Resolution select, 1 = extended |
| busy | output | 1 | Conversion in progress |
| data_valid | output | 1 | A complete result is available |
| rate_code | output | 8 | Rate register read-back |

## Verification
The bench sweeps all ten rate codes and measures the start-to-start interval for each one, along with the resolution select. A wrong shift, or mishandling of code 9, shows up as a wrong interval, and a bad rate threshold flips `res_ext` at codes 6 or 7. It writes reserved nibbles and data with set upper bits. A design that decoded the full byte would change rate or read back non-zero high bits. It rewrites the rate in the middle of a long period, and a design that reloaded immediately would shorten that interval. Finally, it slows completion below the period, pulses one-shot during a conversion, and holds lockout. These expose overlapping starts, a second conversion, or a start that leaks through lockout.

// File: rtl/conv_sched_pkg.sv
// Package: shared constants and types for the conversion rate scheduler.
// Assumes rate codes fit in 4 bits and that code 9 aliases code 8.
package conv_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } sched_state_t;

    localparam int unsigned CODE_W       = 4;
    localparam int unsigned MAX_CODE_I   = 9;
    localparam int unsigned FAST_SHIFT_I = 8;
    localparam logic [CODE_W-1:0] MAX_CODE   = 4'd9;
    localparam logic [CODE_W-1:0] EXT_MAX    = 4'd6;
    localparam logic [CODE_W-1:0] RESET_CODE = 4'd8;
endpackage

// File: rtl/conv_rate_reg.sv
// Module: rate register. Holds the active rate nibble and refuses
// reserved codes. Assumes the write strobe is one cycle per write.
module conv_rate_reg
    import conv_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] nib;
    logic              legal;

    // Decode the low nibble and judge whether it is a usable rate.
    always_comb begin
        nib   = wdata[CODE_W-1:0];
        legal = (nib <= MAX_CODE);
    end

    // Register the nibble on a legal write; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= RESET_CODE;
        else if (we && legal)
            code <= nib;
    end
endmodule

// File: rtl/conv_period_timer.sv
// Module: period timer. Loads the tick count for the given code at each
// start and counts ticks down; 'due' marks that the period has run out
// (or runs out on this tick). Assumes TICK_HZ is a multiple of 16.
module conv_period_timer
    import conv_sched_pkg::*;
#(
    parameter int unsigned TICK_HZ = 64,
    localparam int unsigned SLOW_TICKS = TICK_HZ * 16,
    localparam int unsigned CNT_W = $clog2(SLOW_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              due
);
    localparam logic [CNT_W-1:0] SLOW_P = CNT_W'(SLOW_TICKS);

    logic [CNT_W-1:0] per_tab [MAX_CODE_I+1];
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    // One period constant per rate code, halving per step.
    for (genvar g = 0; g <= int'(MAX_CODE_I); g++) begin : g_per
        localparam int unsigned SH = (g > int'(FAST_SHIFT_I)) ? FAST_SHIFT_I : g;
        assign per_tab[g] = SLOW_P >> SH;
    end

    // Select the period of the requested code.
    always_comb begin
        period = per_tab[MAX_CODE_I];
        for (int i = 0; i <= int'(MAX_CODE_I); i++) begin
            if (code == CODE_W'(i))
                period = per_tab[i];
        end
    end

    // Reload at a start, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= period;
        else if (tick && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Period is over, or is completed by the tick of this cycle.
    always_comb begin
        due = (cnt == '0) || ((cnt == CNT_W'(1)) && tick);
    end
endmodule

// File: rtl/conv_res_sel.sv
// Module: resolution select. Latches the resolution for each conversion
// at its start; extended only when requested and the rate is slow enough.
module conv_res_sel
    import conv_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ext_req,
    input  logic [CODE_W-1:0] code,
    output logic              res_ext
);
    // Capture the permitted resolution at each start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_ext <= 1'b0;
        else if (load)
            res_ext <= ext_req && (code <= EXT_MAX);
    end
endmodule

// File: rtl/conv_seq_fsm.sv
// Module: conversion sequencer. Idle / converting / waiting-for-period
// state machine deciding when a start is issued. Assumes 'done' only
// matters while converting and 'due' comes from the period timer.
module conv_seq_fsm
    import conv_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_stop,
    input  logic standby,
    input  logic one_shot,
    input  logic uvlo,
    input  logic done,
    input  logic due,
    output logic start_now,
    output logic start_q,
    output logic busy,
    output logic valid
);
    sched_state_t state, nxt;
    logic         auto_mode;
    logic         from_idle;
    logic         single_q;

    // Autonomous mode unless paused by either control.
    always_comb begin
        auto_mode = !run_stop && !standby;
    end

    // Next-state and start decision.
    always_comb begin
        nxt       = state;
        start_now = 1'b0;
        from_idle = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!uvlo && (auto_mode || one_shot)) begin
                    start_now = 1'b1;
                    from_idle = 1'b1;
                    nxt       = ST_CONV;
                end
            end
            ST_CONV: begin
                if (done)
                    nxt = (auto_mode && !single_q) ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT: begin
                if (!auto_mode) begin
                    nxt = ST_IDLE;
                end else if (due && !uvlo) begin
                    start_now = 1'b1;
                    nxt       = ST_CONV;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, start strobe and single-conversion marker registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            start_q  <= 1'b0;
            single_q <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= start_now;
            if (start_now)
                single_q <= from_idle && !auto_mode;
        end
    end

    // Result-valid flag: cleared on a fresh start, set at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b0;
        else if (start_now && from_idle)
            valid <= 1'b0;
        else if ((state == ST_CONV) && done)
            valid <= 1'b1;
    end

    // Busy reflects the converting state.
    always_comb begin
        busy = (state == ST_CONV);
    end
endmodule

// File: rtl/conv_sched.sv
// Module: conversion rate scheduler top. Ties the rate register, period
// timer, resolution select and sequencer together. Assumes 'tick' is a
// one-cycle pulse at TICK_HZ and TICK_HZ is a multiple of 16.
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int unsigned TICK_HZ = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rate_we,
    input  logic [7:0] rate_wdata,
    input  logic       run_stop,
    input  logic       standby,
    input  logic       one_shot,
    input  logic       ext_res_req,
    input  logic       uvlo,
    input  logic       conv_done,
    output logic       conv_start,
    output logic       res_ext,
    output logic       busy,
    output logic       data_valid,
    output logic [7:0] rate_code
);
    logic [CODE_W-1:0] code;
    logic              due;
    logic              start_now;

    conv_rate_reg u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rate_we),
        .wdata (rate_wdata),
        .code  (code)
    );

    conv_period_timer #(.TICK_HZ(TICK_HZ)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (start_now),
        .code  (code),
        .due   (due)
    );

    conv_res_sel u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_now),
        .ext_req (ext_res_req),
        .code    (code),
        .res_ext (res_ext)
    );

    conv_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_stop  (run_stop),
        .standby   (standby),
        .one_shot  (one_shot),
        .uvlo      (uvlo),
        .done      (conv_done),
        .due       (due),
        .start_now (start_now),
        .start_q   (conv_start),
        .busy      (busy),
        .valid     (data_valid)
    );

    // Read-back: upper nibble always zero.
    always_comb begin
        rate_code = {4'h0, code};
    end
endmodule

// File: rtl/conv_sched_checker.sv
// Module: property checker for conv_sched, attached by bind.
module conv_sched_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rate_we,
    input logic [7:0] rate_wdata,
    input logic       run_stop,
    input logic       standby,
    input logic       one_shot,
    input logic       uvlo,
    input logic       conv_done,
    input logic       conv_start,
    input logic       res_ext,
    input logic       busy,
    input logic       data_valid,
    input logic [7:0] rate_code
);
    a_r5_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);
    a_r5_busy_rise_is_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_start);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r8_no_start_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !conv_start);
    a_r4_legacy_when_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && ($past(rate_code[3:0]) > 4'd6)) |-> !res_ext);
    a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_we && (rate_wdata[3:0] > 4'd9)) |=> $stable(rate_code));
    a_r9_valid_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && busy) |=> data_valid);
    a_r6_paused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_stop || standby) && !busy && !one_shot) |=> !busy);
endmodule

bind conv_sched conv_sched_checker u_chk (.*);

// File: tb/conv_sched_bench.sv
module conv_sched_bench;
    localparam int TICK_HZ = 32;

    logic       clk = 1'b0;
    logic       rst_n, tick, rate_we, run_stop, standby, one_shot;
    logic       ext_res_req, uvlo, conv_done;
    logic [7:0] rate_wdata;
    logic       conv_start, res_ext, busy, data_valid;
    logic [7:0] rate_code;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int done_lat = 1;
    int dcnt = 0;

    conv_sched #(.TICK_HZ(TICK_HZ)) u_conv_sched (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate_we(rate_we),
        .rate_wdata(rate_wdata), .run_stop(run_stop), .standby(standby),
        .one_shot(one_shot), .ext_res_req(ext_res_req), .uvlo(uvlo),
        .conv_done(conv_done), .conv_start(conv_start), .res_ext(res_ext),
        .busy(busy), .data_valid(data_valid), .rate_code(rate_code)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Converter model: done pulse done_lat cycles after start
    initial begin
        conv_done = 1'b0;
        forever begin
            @(negedge clk);
            if (conv_done) begin
                conv_done = 1'b0;
                dcnt = 0;
            end else if (busy) begin
                dcnt++;
                if (dcnt >= done_lat) conv_done = 1'b1;
            end else begin
                dcnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int per_of(input int code);
        int sh;
        sh = (code > 8) ? 8 : code;
        return (TICK_HZ * 16) >> sh;
    endfunction

    task automatic next_start(output int t);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_start && n < 5000);
        if (n >= 5000) chk(0, "start timeout", n, 0);
        t = cyc;
    endtask

    task automatic count_starts(input int ncy, output int k);
        k = 0;
        for (int i = 0; i < ncy; i++) begin
            @(negedge clk);
            if (conv_start) k++;
        end
    endtask

    task automatic write_rate(input logic [7:0] d);
        @(negedge clk);
        rate_we = 1'b1;
        rate_wdata = d;
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    initial begin
        int t0, t1, t2, k, ex;
        rst_n = 1'b0; tick = 1'b1; rate_we = 1'b0; rate_wdata = 8'h00;
        run_stop = 1'b0; standby = 1'b0; one_shot = 1'b0;
        ext_res_req = 1'b0; uvlo = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_start == 1'b0 && busy == 1'b0, "R10 reset idle", busy, 0);
        chk(data_valid == 1'b0, "R9 reset valid", data_valid, 0);
        chk(rate_code == 8'h08, "R2 reset code", rate_code, 8);
        chk(res_ext == 1'b0, "R4 reset legacy", res_ext, 0);
        count_starts(20, k);
        chk(k == 0, "R8 lockout at power-up", k, 0);
        uvlo = 1'b0;
        @(negedge clk);
        chk(conv_start == 1'b1 && busy == 1'b1, "R8/R10 start after lockout", conv_start, 1);
        chk(data_valid == 1'b0, "R9 not valid at start", data_valid, 0);
        chk(res_ext == 1'b0, "R10 legacy first conversion", res_ext, 0);
        @(negedge clk);
        @(negedge clk);
        chk(data_valid == 1'b1, "R9 valid after done", data_valid, 1);

        // R1 / R4 sweep of all codes
        ext_res_req = 1'b1;
        for (int c = 0; c <= 9; c++) begin
            write_rate(8'(c));
            chk(rate_code == 8'(c), "R2 readback", rate_code, c);
            next_start(t0);
            next_start(t1);
            next_start(t2);
            ex = per_of(c);
            chk(t2 - t1 == ex, $sformatf("R1 period code %0d", c), t2 - t1, ex);
            chk(res_ext == (c <= 6), $sformatf("R4 resolution code %0d", c), res_ext, (c <= 6));
        end

        // R2 upper nibble ignored, reserved nibble ignored
        write_rate(8'h35);
        chk(rate_code == 8'h05, "R2 upper nibble", rate_code, 5);
        write_rate(8'h0C);
        chk(rate_code == 8'h05, "R2 reserved 0C", rate_code, 5);
        write_rate(8'hFA);
        chk(rate_code == 8'h05, "R2 reserved FA", rate_code, 5);
        next_start(t0); next_start(t1); next_start(t2);
        chk(t2 - t1 == per_of(5), "R2 rate kept after reserved", t2 - t1, per_of(5));

        // R3 mid-period write
        write_rate(8'h00);
        next_start(t0); next_start(t0);
        repeat (10) @(negedge clk);
        rate_we = 1'b1; rate_wdata = 8'h08;
        @(negedge clk);
        rate_we = 1'b0;
        next_start(t1);
        chk(t1 - t0 == per_of(0), "R3 running period kept", t1 - t0, per_of(0));
        next_start(t2);
        chk(t2 - t1 == per_of(8), "R3 new period applied", t2 - t1, per_of(8));

        // R5 slow completion
        done_lat = 10;
        next_start(t0); next_start(t1); next_start(t2);
        chk(t2 - t1 == 11, "R5 back-to-back after done", t2 - t1, 11);
        done_lat = 1;

        // R6 stop
        write_rate(8'h04);
        next_start(t0);
        run_stop = 1'b1;
        count_starts(200, k);
        chk(k == 0, "R6 no starts while stopped", k, 0);
        chk(busy == 1'b0, "R6 idle while stopped", busy, 0);

        // R7 one-shot while stopped, second one-shot during conversion
        done_lat = 5;
        one_shot = 1'b1;
        @(negedge clk);
        one_shot = 1'b0;
        chk(conv_start == 1'b1, "R7 one-shot starts", conv_start, 1);
        chk(data_valid == 1'b0, "R9 cleared on one-shot", data_valid, 0);
        @(negedge clk);
        one_shot = 1'b1;
        @(negedge clk);
        one_shot = 1'b0;
        count_starts(150, k);
        chk(k == 0, "R7 single conversion only", k, 0);
        chk(busy == 1'b0, "R7 back to idle", busy, 0);
        chk(data_valid == 1'b1, "R9 valid after one-shot", data_valid, 1);
        done_lat = 1;

        run_stop = 1'b0;
        @(negedge clk);
        chk(conv_start == 1'b1, "R6 start on leaving stop", conv_start, 1);
        chk(data_valid == 1'b0, "R9 cleared on leaving stop", data_valid, 0);

        // R6 standby
        repeat (5) @(negedge clk);
        standby = 1'b1;
        count_starts(100, k);
        chk(k == 0, "R6 no starts in standby", k, 0);
        standby = 1'b0;
        @(negedge clk);
        chk(conv_start == 1'b1, "R6 start on standby release", conv_start, 1);

        // R8 lockout during autonomous running
        write_rate(8'h08);
        next_start(t0); next_start(t0);
        uvlo = 1'b1;
        count_starts(50, k);
        chk(k == 0, "R8 no starts in lockout", k, 0);
        uvlo = 1'b0;
        @(negedge clk);
        chk(conv_start == 1'b1, "R8 held start issued on release", conv_start, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule